// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the slave-side register file of a multi-channel DMA controller for chained buffers. It serves up to eight channels. Each channel has its own 4 KB window in the address space and holds the configuration the channel engine needs: the descriptor addresses for source and destination as 64-bit values split into low and high words, the buffer counts for both sides, the buffer size and a polling period. A period of zero selects out-of-order scanning, and the period resets to zero.

One run register per channel both starts and stops the channel. A non-zero write to an idle channel marks it busy and sends a one-cycle start pulse to the engine. A zero write forces the channel back to idle and sends a one-cycle abort pulse. The engines report bus errors through a valid bit and a 3-bit code. A running channel that receives such a report moves into that error code and raises its private interrupt line. The line stays high until software writes zero to the run register.

The bus side uses a single-beat request with a registered response one cycle later. Any access to an undefined location gets an error response and changes no state.

Top module: `dmab_regbank`

## Requirements
- R1: The channel is `req_addr[14:12]` and the register number is `req_addr[4:0]`. Address bits above 14 are ignored. An access gets an error response, `rdata` 0 and no state change when any of these holds: the channel is at or above `NUM_CH`, the register number is above 9, or `req_addr[11:5]` is non-zero.
- R2: Each accepted request cycle produces exactly one `rsp_valid` pulse in the following cycle. Cycles with no request produce none. Write responses carry `rdata` 0.
- R3: Register numbers map as follows: 2 source-descriptor low, 3 source-descriptor high, 4 destination-descriptor low, 5 destination-descriptor high, 6 source buffer count, 7 destination buffer count, 8 buffer size, 9 polling period. All of them reset to 0 and read back the last value written. They drive the `cfg_*` outputs, with the high words in bits [63:32] of each channel's 64-bit descriptor slice.
- R4: Register 0 is the run register. A non-zero write to a channel in status 0 sets its status to 5 (busy) and raises `ch_start` for exactly one cycle. A non-zero write to a busy or failed channel changes nothing and raises no start.
- R5: A zero write to the run register sets the status to 0, clears the interrupt and raises `ch_abort` for one cycle.
- R6: Register 1 is the read-only status, and it reads as the code in bits [2:0]. A read of the run register gets an error response, and so does a write to the status register. The status is not changed by such a write.
- R7: An engine report with code 1 to 4 moves a busy channel into that code. The codes are 1 source descriptor, 2 destination descriptor, 3 source data and 4 destination data. Reports made while the channel is idle or already failed are ignored, and so are reports with code 0 or above 4.
- R8: `ch_irq[k]` is high exactly while channel k holds an error code 1 to 4, and it rises only when a busy channel fails.
- R9: A write to one channel leaves every other channel's registers, status and outputs unchanged.
- R10: When a zero run write and an engine error report reach the same channel in the same cycle, the channel ends idle with its interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data (0 on error or write) |
| eng_err_valid | input | NUM_CH | Engine error report per channel |
| eng_err_code | input | 3*NUM_CH | Error code per channel |
| ch_start | output | NUM_CH | One-cycle start pulse |
| ch_abort | output | NUM_CH | One-cycle abort pulse |
| ch_irq | output | NUM_CH | Error interrupt per channel |
| cfg_src_desc | output | 64*NUM_CH | Source descriptor address per channel |
| cfg_dst_desc | output | 64*NUM_CH | Destination descriptor address per channel |
| cfg_src_nbufs | output | 32*NUM_CH | Source buffer count per channel |
| cfg_dst_nbufs | output | 32*NUM_CH | Destination buffer count per channel |
| cfg_buf_size | output | 32*NUM_CH | Buffer size per channel |
| cfg_period | output | 32*NUM_CH | Polling period per channel |

## Verification
The assertions check several properties on every cycle:
- every request gets a response one cycle later, and no response appears without a request;
- an access to a missing channel is always refused;
- a start pulse comes only from an idle channel;
- an abort always leaves the channel idle with its interrupt low;
- an interrupt rises only out of the busy state;
- the status code never leaves its legal range.

Other behaviours can only be shown by the bench's scenarios:
- read-back of the configuration words and where they land on the `cfg_*` outputs;
- that a refused write leaves the targeted register unchanged;
- that other channels stay untouched;
- that an error report is ignored when the channel is idle or already failed, or when the code is out of range;
- that a zero write wins over an error report arriving in the same cycle.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    localparam int MAX_CH   = 8;
    localparam int NUM_REGS = 10;
    localparam int RID_W    = 5;
    localparam int CODE_W   = 3;

    localparam logic [RID_W-1:0] RG_RUN      = 5'd0;
    localparam logic [RID_W-1:0] RG_STATUS   = 5'd1;
    localparam logic [RID_W-1:0] RG_SRC_LO   = 5'd2;
    localparam logic [RID_W-1:0] RG_SRC_HI   = 5'd3;
    localparam logic [RID_W-1:0] RG_DST_LO   = 5'd4;
    localparam logic [RID_W-1:0] RG_DST_HI   = 5'd5;
    localparam logic [RID_W-1:0] RG_SRC_CNT  = 5'd6;
    localparam logic [RID_W-1:0] RG_DST_CNT  = 5'd7;
    localparam logic [RID_W-1:0] RG_BUF_SIZE = 5'd8;
    localparam logic [RID_W-1:0] RG_PERIOD   = 5'd9;

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE         = 3'd0,
        ST_SRC_DESC_ERR = 3'd1,
        ST_DST_DESC_ERR = 3'd2,
        ST_SRC_DATA_ERR = 3'd3,
        ST_DST_DATA_ERR = 3'd4,
        ST_BUSY         = 3'd5
    } ch_state_e;

    typedef struct packed {
        logic [31:0] src_lo;
        logic [31:0] src_hi;
        logic [31:0] dst_lo;
        logic [31:0] dst_hi;
        logic [31:0] src_cnt;
        logic [31:0] dst_cnt;
        logic [31:0] buf_size;
        logic [31:0] period;
    } ch_cfg_t;

    typedef struct packed {
        logic              ok;
        logic [2:0]        chan;
        logic [RID_W-1:0]  rid;
    } dec_t;

    function automatic logic is_err_code(input logic [CODE_W-1:0] c);
        return (c >= 3'd1) && (c <= 3'd4);
    endfunction

    function automatic logic [31:0] read_field(input ch_cfg_t cfg,
                                               input logic [CODE_W-1:0] st,
                                               input logic [RID_W-1:0] rid);
        logic [31:0] v;
        case (rid)
            RG_STATUS:   v = {29'd0, st};
            RG_SRC_LO:   v = cfg.src_lo;
            RG_SRC_HI:   v = cfg.src_hi;
            RG_DST_LO:   v = cfg.dst_lo;
            RG_DST_HI:   v = cfg.dst_hi;
            RG_SRC_CNT:  v = cfg.src_cnt;
            RG_DST_CNT:  v = cfg.dst_cnt;
            RG_BUF_SIZE: v = cfg.buf_size;
            RG_PERIOD:   v = cfg.period;
            default:     v = 32'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
    import dmab_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [NUM_CH-1:0] wr_sel
);

    logic [2:0]       chan;
    logic [RID_W-1:0] rid;
    logic             in_range;
    logic             dir_ok;

    assign chan     = addr[14:12];
    assign rid      = addr[4:0];
    assign in_range = (32'(chan) < NUM_CH) && (32'(rid) < NUM_REGS)
                      && (addr[11:5] == 7'd0);
    assign dir_ok   = write ? (rid != RG_STATUS) : (rid != RG_RUN);

    assign dec.ok   = in_range && dir_ok;
    assign dec.chan = chan;
    assign dec.rid  = rid;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
        assign wr_sel[k] = valid && write && dec.ok && (32'(chan) == k);
    end

    // R9: at most one channel is written per cycle
    p_single_target_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

endmodule

// File: rtl/dmab_chan.sv
module dmab_chan
    import dmab_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [RID_W-1:0]   rid,
    input  logic [31:0]        wdata,
    input  logic               err_valid,
    input  logic [CODE_W-1:0]  err_code,
    output ch_cfg_t            cfg,
    output logic [CODE_W-1:0]  state,
    output logic               start,
    output logic               abort,
    output logic               irq
);

    ch_state_e st_q;
    logic      run_wr;

    assign run_wr = wr_en && (rid == RG_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (rid)
                RG_SRC_LO:   cfg.src_lo   <= wdata;
                RG_SRC_HI:   cfg.src_hi   <= wdata;
                RG_DST_LO:   cfg.dst_lo   <= wdata;
                RG_DST_HI:   cfg.dst_hi   <= wdata;
                RG_SRC_CNT:  cfg.src_cnt  <= wdata;
                RG_DST_CNT:  cfg.dst_cnt  <= wdata;
                RG_BUF_SIZE: cfg.buf_size <= wdata;
                RG_PERIOD:   cfg.period   <= wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            start <= 1'b0;
            abort <= 1'b0;
        end else begin
            start <= 1'b0;
            abort <= 1'b0;
            if (run_wr && wdata == 32'd0) begin
                st_q  <= ST_IDLE;
                abort <= 1'b1;
            end else if (run_wr && st_q == ST_IDLE) begin
                st_q  <= ST_BUSY;
                start <= 1'b1;
            end else if (err_valid && st_q == ST_BUSY && is_err_code(err_code)) begin
                st_q <= ch_state_e'(err_code);
            end
        end
    end

    assign state = st_q;
    assign irq   = is_err_code(st_q);

    p_start_from_idle_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(st_q) == ST_IDLE);
    p_abort_clears_r5: assert property (@(posedge clk) disable iff (rst)
        abort |-> (st_q == ST_IDLE) && !irq);
    p_irq_from_busy_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(st_q) == ST_BUSY);
    p_state_legal_r7: assert property (@(posedge clk) disable iff (rst)
        st_q <= ST_BUSY);

endmodule

// File: rtl/dmab_regbank.sv
module dmab_regbank
    import dmab_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    input  logic [NUM_CH-1:0]    eng_err_valid,
    input  logic [3*NUM_CH-1:0]  eng_err_code,
    output logic [NUM_CH-1:0]    ch_start,
    output logic [NUM_CH-1:0]    ch_abort,
    output logic [NUM_CH-1:0]    ch_irq,
    output logic [64*NUM_CH-1:0] cfg_src_desc,
    output logic [64*NUM_CH-1:0] cfg_dst_desc,
    output logic [32*NUM_CH-1:0] cfg_src_nbufs,
    output logic [32*NUM_CH-1:0] cfg_dst_nbufs,
    output logic [32*NUM_CH-1:0] cfg_buf_size,
    output logic [32*NUM_CH-1:0] cfg_period
);

    dec_t              dec;
    logic [NUM_CH-1:0] wr_sel;
    ch_cfg_t           cfg_a [NUM_CH];
    logic [CODE_W-1:0] st_a  [NUM_CH];
    logic [31:0]       rd_mux;

    dmab_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .valid  (req_valid),
        .write  (req_write),
        .addr   (req_addr),
        .dec    (dec),
        .wr_sel (wr_sel)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        dmab_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_sel[k]),
            .rid       (dec.rid),
            .wdata     (req_wdata),
            .err_valid (eng_err_valid[k]),
            .err_code  (eng_err_code[k*CODE_W +: CODE_W]),
            .cfg       (cfg_a[k]),
            .state     (st_a[k]),
            .start     (ch_start[k]),
            .abort     (ch_abort[k]),
            .irq       (ch_irq[k])
        );
        assign cfg_src_desc [k*64 +: 64] = {cfg_a[k].src_hi, cfg_a[k].src_lo};
        assign cfg_dst_desc [k*64 +: 64] = {cfg_a[k].dst_hi, cfg_a[k].dst_lo};
        assign cfg_src_nbufs[k*32 +: 32] = cfg_a[k].src_cnt;
        assign cfg_dst_nbufs[k*32 +: 32] = cfg_a[k].dst_cnt;
        assign cfg_buf_size [k*32 +: 32] = cfg_a[k].buf_size;
        assign cfg_period   [k*32 +: 32] = cfg_a[k].period;
    end

    always_comb begin
        rd_mux = 32'd0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (32'(dec.chan) == k)
                rd_mux = read_field(cfg_a[k], st_a[k], dec.rid);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= 32'd0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !dec.ok;
            rsp_rdata <= (req_valid && !req_write && dec.ok) ? rd_mux : 32'd0;
        end
    end

    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_missing_chan_err_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (32'(req_addr[14:12]) >= NUM_CH)) |=> (rsp_err && rsp_rdata == 32'd0));

endmodule

// File: tb/dmab_regbank_bench.sv
module dmab_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NVEC = 20;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [31:0]         req_addr = '0;
    logic [31:0]         req_wdata = '0;
    logic                rsp_valid, rsp_err;
    logic [31:0]         rsp_rdata;
    logic [NCH-1:0]      eng_err_valid = '0;
    logic [3*NCH-1:0]    eng_err_code = '0;
    logic [NCH-1:0]      ch_start, ch_abort, ch_irq;
    logic [64*NCH-1:0]   cfg_src_desc, cfg_dst_desc;
    logic [32*NCH-1:0]   cfg_src_nbufs, cfg_dst_nbufs, cfg_buf_size, cfg_period;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmab_regbank #(.NUM_CH(NCH), .ADDR_W(32)) u_dmab_regbank (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .eng_err_valid(eng_err_valid), .eng_err_code(eng_err_code),
        .ch_start(ch_start), .ch_abort(ch_abort), .ch_irq(ch_irq),
        .cfg_src_desc(cfg_src_desc), .cfg_dst_desc(cfg_dst_desc),
        .cfg_src_nbufs(cfg_src_nbufs), .cfg_dst_nbufs(cfg_dst_nbufs),
        .cfg_buf_size(cfg_buf_size), .cfg_period(cfg_period)
    );

    // vector: {write, addr, wdata, exp_err, exp_rdata}
    localparam logic [97:0] VEC [NVEC] = '{
        {1'b1, 32'h0000_0002, 32'h1000_0040, 1'b0, 32'h0},          // R3
        {1'b0, 32'h0000_0002, 32'h0,         1'b0, 32'h1000_0040},   // R3
        {1'b1, 32'h0000_0003, 32'h0000_00AB, 1'b0, 32'h0},          // R3
        {1'b0, 32'h0000_0003, 32'h0,         1'b0, 32'h0000_00AB},   // R3
        {1'b1, 32'h0000_1009, 32'h0000_0007, 1'b0, 32'h0},          // R3
        {1'b0, 32'h0000_1009, 32'h0,         1'b0, 32'h0000_0007},   // R3
        {1'b0, 32'h0000_0009, 32'h0,         1'b0, 32'h0},          // R9
        {1'b0, 32'h0000_0000, 32'h0,         1'b1, 32'h0},          // R6
        {1'b1, 32'h0000_0001, 32'h0000_0005, 1'b1, 32'h0},          // R6
        {1'b0, 32'h0000_0001, 32'h0,         1'b0, 32'h0},          // R6
        {1'b1, 32'h0000_5002, 32'h0000_0055, 1'b1, 32'h0},          // R1
        {1'b0, 32'h0000_5002, 32'h0,         1'b1, 32'h0},          // R1
        {1'b1, 32'h0000_000A, 32'h0000_0001, 1'b1, 32'h0},          // R1
        {1'b0, 32'h0000_001F, 32'h0,         1'b1, 32'h0},          // R1
        {1'b1, 32'h0000_2042, 32'h0000_0099, 1'b1, 32'h0},          // R1
        {1'b0, 32'h0000_2002, 32'h0,         1'b0, 32'h0},          // R1
        {1'b1, 32'h0000_3008, 32'h0000_0800, 1'b0, 32'h0},          // R3
        {1'b0, 32'h8001_3008, 32'h0,         1'b0, 32'h0000_0800},   // R1 high bits ignored
        {1'b1, 32'h0000_0004, 32'h0000_2000, 1'b0, 32'h0},          // R3
        {1'b0, 32'h0000_0004, 32'h0,         1'b0, 32'h0000_2000}    // R3
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                          output logic e, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        e = rsp_err; r = rsp_rdata;
        chk("R2 rsp_valid after request", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic status_is(input int ch, input logic [31:0] exp, input string tag);
        logic e; logic [31:0] r;
        access(1'b0, 32'(ch) << 12 | 32'd1, 32'd0, e, r);
        chk(tag, {31'd0, e, r}, {31'd0, 1'b0, exp});
    endtask

    task automatic report(input int ch, input logic [2:0] code);
        @(negedge clk);
        eng_err_valid[ch] = 1'b1; eng_err_code[ch*3 +: 3] = code;
        @(negedge clk);
        eng_err_valid = '0; eng_err_code = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic e; logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // reset state (R2 R3 R8)
        chk("R2 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R8 reset irq", {60'd0, ch_irq}, 64'd0);
        chk("R3 reset period", cfg_period[63:0], 64'd0);
        chk("R3 reset src desc", cfg_src_desc[63:0], 64'd0);
        chk("R4 reset start", {56'd0, ch_start, ch_abort}, 64'd0);

        // table walk (R1 R3 R6 R9)
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][97], VEC[i][96:65], VEC[i][64:33], e, r);
            chk($sformatf("R1/R3/R6/R9 vector %0d err", i), {63'd0, e}, {63'd0, VEC[i][32]});
            chk($sformatf("R1/R3/R6/R9 vector %0d rdata", i), {32'd0, r}, {32'd0, VEC[i][31:0]});
        end
        @(negedge clk);
        chk("R2 no response when idle", {63'd0, rsp_valid}, 64'd0);
        chk("R3 src desc output ch0", cfg_src_desc[63:0], {32'h0000_00AB, 32'h1000_0040});
        chk("R3 dst desc output ch0", cfg_dst_desc[63:0], {32'h0, 32'h0000_2000});
        chk("R3 period output ch1", {32'd0, cfg_period[63:32]}, 64'd7);
        chk("R9 period output ch0", {32'd0, cfg_period[31:0]}, 64'd0);
        chk("R3 buf size output ch3", {32'd0, cfg_buf_size[127:96]}, 64'h800);
        chk("R1 ignored write ch2", {32'd0, cfg_src_desc[159:128]}, 64'd0);

        // R4 start from idle
        access(1'b1, 32'h0000_1000, 32'd1, e, r);
        chk("R4 start pulse ch1 only", {60'd0, ch_start}, 64'b0010);
        @(negedge clk);
        chk("R4 start lasts one cycle", {60'd0, ch_start}, 64'd0);
        status_is(1, 32'd5, "R4 status busy");
        access(1'b1, 32'h0000_1000, 32'd3, e, r);
        chk("R4 no restart while busy", {60'd0, ch_start}, 64'd0);
        chk("R9 other status idle", {60'd0, ch_irq}, 64'd0);
        status_is(0, 32'd0, "R9 ch0 still idle");

        // R7 R8 error entry
        report(1, 3'd3);
        chk("R8 irq on error ch1", {60'd0, ch_irq}, 64'b0010);
        status_is(1, 32'd3, "R7 status source data error");
        report(1, 3'd4);
        status_is(1, 32'd3, "R7 report ignored in error state");
        report(0, 3'd2);
        chk("R7 idle report no irq", {60'd0, ch_irq}, 64'b0010);
        status_is(0, 32'd0, "R7 idle report ignored");
        access(1'b1, 32'h0000_1000, 32'd1, e, r);
        chk("R4 no start from error", {60'd0, ch_start}, 64'd0);
        status_is(1, 32'd3, "R4 error state kept");

        // R5 abort
        access(1'b1, 32'h0000_1000, 32'd0, e, r);
        chk("R5 abort pulse ch1", {60'd0, ch_abort}, 64'b0010);
        chk("R5 irq cleared", {60'd0, ch_irq}, 64'd0);
        status_is(1, 32'd0, "R5 status idle");

        // R7 invalid codes
        access(1'b1, 32'h0000_3000, 32'h10, e, r);
        chk("R4 start ch3", {60'd0, ch_start}, 64'b1000);
        report(3, 3'd6);
        status_is(3, 32'd5, "R7 code 6 ignored");
        report(3, 3'd0);
        status_is(3, 32'd5, "R7 code 0 ignored");
        report(3, 3'd1);
        status_is(3, 32'd1, "R7 source descriptor error");
        chk("R8 irq ch3", {60'd0, ch_irq}, 64'b1000);

        // R10 zero write races an error report
        access(1'b1, 32'h0000_2000, 32'd1, e, r);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_2000; req_wdata = 32'd0;
        eng_err_valid[2] = 1'b1; eng_err_code[8:6] = 3'd2;
        @(negedge clk);
        req_valid = 1'b0; eng_err_valid = '0; eng_err_code = '0;
        chk("R10 irq low after race", {63'd0, ch_irq[2]}, 64'd0);
        chk("R10 abort pulse", {63'd0, ch_abort[2]}, 64'd1);
        status_is(2, 32'd0, "R10 status idle after race");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule